// File: doc/BRIEF.md
# Strobe-Addressed Serial Receiver Card

This block is one receiving card on a broadcast serial bus driven by a single master. The master drives three lines to every card at once: a shift clock, a data line and a strobe. The card shifts a bit in from the data line on every rising edge of the shift clock. It keeps a short history of the most recent bytes. Every card also owns a tap on one shared return line back to the master.

Addressing is settled after the bytes have arrived. When the master pulses the strobe, every card compares the newest byte in its history with its own address, which comes from an input port. Only the card whose address matches copies the two bytes that came before the address into its output registers. That card also takes the return line and loads a status byte, which leaves the card one bit per clock rise during the next transfer. A card whose address does not match keeps its outputs as they were and releases the return line.

The bus lines are asynchronous to the card's system clock. They are passed through synchronizers and edge-detected before use, so each bus event reaches the card a few system cycles after the pin changes.

Top module: `strobe_card`

## Requirements
- R1: After reset, `payload_o` is all zeros, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: Each rising edge of `bus_sclk_i` shifts one bit from `bus_sdi_i` into a three-byte history. Bits arrive most significant bit first.
- R3: A rising edge of `bus_strobe_i` compares the most recently completed byte (the last eight bits shifted in) with `card_addr_i`.
- R4: On a match, `payload_o` loads the two bytes received before the address byte. The earlier of the two goes to bits [15:8] and the later to bits [7:0].
- R5: On a match, `sdo_oe_o` goes to 1 and stays there until the next strobe rising edge.
- R6: On a mismatch, `payload_o` keeps its value and `sdo_oe_o` goes to 0.
- R7: On a match, `status_i` is captured at the strobe. Its bit 7 appears on `sdo_o` first, and each later rising edge of `bus_sclk_i` advances by one bit. Zeros follow once all eight bits have been sent.
- R8: `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R9: Changes on `bus_sdi_i` or falling edges of `bus_sclk_i`, with no rising clock edge, do not alter the history. A following strobe gives the same result as it would without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_addr_i | input | 8 | Address of this card |
| status_i | input | 8 | Byte returned to the master after a match |
| bus_sclk_i | input | 1 | Bus shift clock from the master |
| bus_sdi_i | input | 1 | Bus serial data from the master |
| bus_strobe_i | input | 1 | Bus strobe from the master |
| sdo_o | output | 1 | Return-line data bit |
| sdo_oe_o | output | 1 | Return-line driver enable |
| payload_o | output | 16 | Latched payload bytes |

## Verification
The assertions assume a well-behaved master. A strobe edge and a shift-clock edge never reach the card in the same system cycle, and every bus line holds each level for longer than the synchronizer latency. The stimulus holds every bus level for several system cycles, and it only changes a line at the falling edge of the system clock. It also separates a strobe pulse from the nearest clock rise by at least six cycles. The random frames therefore stay inside these assumptions, while still varying the frame length, the address hit or miss, and the status value.

// File: rtl/strobe_card_pkg.sv
package strobe_card_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum int unsigned {
    LINE_SCLK = 0,
    LINE_SDI  = 1,
    LINE_STB  = 2
  } bus_line_e;
  localparam int unsigned N_LINES = 3;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/shift_hist.sv
module shift_hist #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned HW   = W * DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [HW-1:0] hist_o
);
  logic [HW-1:0] hist_q;

  // newest bit enters at bit 0, so bytes arrive msb first
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HW-2:0], bit_i};

  assign hist_o = hist_q;
endmodule

// File: rtl/ret_shifter.sv
module ret_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= load_val_i;
    else if (shift_i) q <= {q[W-2:0], 1'b0};

  assign bit_o = q[W-1];
endmodule

// File: rtl/strobe_card.sv
module strobe_card
  import strobe_card_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 2,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned PW = PAYLOAD_BYTES * BYTE_W,
  localparam int unsigned HD = PAYLOAD_BYTES + 1,
  localparam int unsigned HW = HD * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] card_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              bus_sclk_i,
  input  logic              bus_sdi_i,
  input  logic              bus_strobe_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [PW-1:0]     payload_o
);
  logic [N_LINES-1:0] lines, lvl, rise;
  logic               sclk_rise, strobe_rise, sdi_lvl;
  logic [HW-1:0]      hist;
  logic [BYTE_W-1:0]  addr_byte;
  logic               hit;
  logic               ret_bit;
  logic               oe_q;
  logic [PW-1:0]      payload_q;

  always_comb begin
    lines            = '0;
    lines[LINE_SCLK] = bus_sclk_i;
    lines[LINE_SDI]  = bus_sdi_i;
    lines[LINE_STB]  = bus_strobe_i;
  end

  bus_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .line_i(lines), .lvl_o(lvl), .rise_o(rise)
  );

  assign sclk_rise   = rise[LINE_SCLK];
  assign strobe_rise = rise[LINE_STB];
  assign sdi_lvl     = lvl[LINE_SDI];

  shift_hist #(.W(BYTE_W), .DEPTH(HD)) i_hist (
    .clk_i, .rst_ni, .shift_i(sclk_rise), .bit_i(sdi_lvl), .hist_o(hist)
  );

  assign addr_byte = hist[BYTE_W-1:0];
  assign hit       = (addr_byte == card_addr_i);

  ret_shifter #(.W(BYTE_W)) i_ret (
    .clk_i, .rst_ni,
    .load_i    (strobe_rise & hit),
    .load_val_i(status_i),
    .shift_i   (sclk_rise),
    .bit_o     (ret_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      oe_q      <= 1'b0;
      payload_q <= '0;
    end else if (strobe_rise) begin
      oe_q <= hit;
      if (hit) payload_q <= hist[HW-1:BYTE_W];
    end

  assign sdo_oe_o  = oe_q;
  assign sdo_o     = oe_q & ret_bit;
  assign payload_o = payload_q;
endmodule

module strobe_card_chk #(
  parameter int unsigned PW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          strobe_rise,
  input logic          sclk_rise,
  input logic [7:0]    addr_byte,
  input logic [7:0]    card_addr_i,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic [PW-1:0] payload_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> !sdo_oe_o); // R1
  AST_HIT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rise && addr_byte == card_addr_i |=> sdo_oe_o); // R5
  AST_OE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_rise |=> $stable(sdo_oe_o)); // R5
  AST_MISS_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rise && addr_byte != card_addr_i |=> !sdo_oe_o); // R6
  AST_MISS_KEEPS_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rise && addr_byte != card_addr_i |=> $stable(payload_o)); // R6
  AST_PAYLOAD_ONLY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_rise |=> $stable(payload_o)); // R4
  AST_SDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R8
  AST_EDGES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_rise && sclk_rise)); // R3
endmodule

bind strobe_card strobe_card_chk #(.PW(PW)) i_chk (
  .clk_i, .rst_ni, .strobe_rise, .sclk_rise, .addr_byte, .card_addr_i,
  .sdo_o, .sdo_oe_o, .payload_o
);

// File: tb/test_strobe_card.sv
module test_strobe_card;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  card_addr_i = 8'h5a;
  logic [7:0]  status_i = 8'h00;
  logic        bus_sclk_i = 1'b0;
  logic        bus_sdi_i = 1'b0;
  logic        bus_strobe_i = 1'b0;
  logic        sdo_o, sdo_oe_o;
  logic [15:0] payload_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [23:0] m_hist = '0;
  logic [15:0] m_payload = '0;
  logic        m_oe = 1'b0;
  logic [7:0]  m_ret = '0;

  localparam int HOLD = 5;

  always #4 clk_i = ~clk_i;

  strobe_card i_strobe_card (
    .clk_i, .rst_ni, .card_addr_i, .status_i, .bus_sclk_i, .bus_sdi_i,
    .bus_strobe_i, .sdo_o, .sdo_oe_o, .payload_o
  );

  function automatic logic exp_sdo();
    return m_oe & m_ret[7];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // R2 R7: shift a byte msb first, checking each return bit before its rise
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      bus_sdi_i = b[i];
      wait_cyc(HOLD);
      chk("R7 sdo", {15'd0, sdo_o}, {15'd0, exp_sdo()});
      bus_sclk_i = 1'b1;
      m_hist = {m_hist[22:0], b[i]};
      m_ret  = {m_ret[6:0], 1'b0};
      wait_cyc(HOLD);
      bus_sclk_i = 1'b0;
    end
    wait_cyc(HOLD);
  endtask

  task automatic strobe();
    if (m_hist[7:0] == card_addr_i) begin
      m_oe = 1'b1; m_payload = m_hist[23:8]; m_ret = status_i;
    end else m_oe = 1'b0;
    bus_strobe_i = 1'b1;
    wait_cyc(HOLD + 1);
    bus_strobe_i = 1'b0;
    wait_cyc(HOLD + 1);
    chk("R4 R6 payload", payload_o, m_payload);
    chk("R5 R6 oe", {15'd0, sdo_oe_o}, {15'd0, m_oe});
    chk("R8 sdo", {15'd0, sdo_o}, {15'd0, exp_sdo()});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    wait_cyc(3);
    chk("R1 payload", payload_o, 16'h0000);
    chk("R1 oe", {15'd0, sdo_oe_o}, 16'h0000);
    chk("R1 sdo", {15'd0, sdo_o}, 16'h0000);
    rst_ni = 1'b1;
    wait_cyc(3);

    // R3 R4 R5 directed hit
    status_i = 8'hc3;
    send_byte(8'ha5); send_byte(8'h3c); send_byte(8'h5a);
    strobe();
    chk("R4 order", payload_o, 16'ha53c);
    // R7: status returns during the next byte, then zeros
    send_byte(8'h11);
    send_byte(8'h22);
    // R6 miss keeps payload and releases line
    send_byte(8'h77); send_byte(8'h88); send_byte(8'h59);
    strobe();
    chk("R6 keep", payload_o, 16'ha53c);
    // long frame: only the last three bytes count (R2)
    status_i = 8'h81;
    send_byte(8'h01); send_byte(8'h02); send_byte(8'hde);
    send_byte(8'had); send_byte(8'h5a);
    strobe();
    chk("R2 window", payload_o, 16'hdead);
    // R9: sdi wiggles and no rising clock edge
    for (int k = 0; k < 6; k++) begin
      bus_sdi_i = k[0];
      wait_cyc(HOLD);
    end
    status_i = 8'h7e;
    strobe();
    chk("R9 same", payload_o, 16'hdead);
    send_byte(8'h00);
    // address change: R3 compares with the port value
    card_addr_i = 8'h00;
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h00);
    strobe();
    chk("R3 new addr", payload_o, 16'h1234);

    // random frames
    for (int f = 0; f < 60; f++) begin
      int unsigned nb;
      nb = 3 + ($urandom % 3);
      card_addr_i = 8'($urandom);
      status_i    = 8'($urandom);
      for (int j = 0; j < int'(nb) - 1; j++) send_byte(8'($urandom));
      if ($urandom % 2) send_byte(card_addr_i);
      else send_byte(card_addr_i ^ 8'(1 + ($urandom % 255)));
      strobe();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule